// File: doc/BRIEF.md
# Video Memory Block Copy Engine

This engine moves data from anywhere in a 16-bit address space into a fixed 8 KB video memory window, always in whole 16-byte blocks. Software loads a source address and a destination address through four byte-wide registers. A single control byte then starts the copy. That byte also selects the block count and the pacing. In general mode every block is copied back to back while the CPU is held off. In H-blank mode one block is copied for each H-blank pulse, so the copy is spread across a frame.

Each byte takes two cycles. The engine reads the source in one cycle and writes the captured byte to the destination in the next. The internal addresses advance after every block, so a later transfer continues where the previous one stopped unless software reloads them. Only the control register can be read back. It reports whether a transfer is armed and how many blocks are left.

Top module: `vdma_ctrl`

## Requirements
- R1: After reset the control register (offset 0x55) reads 0xFF, the stall output is low and no memory write is issued; every other offset reads 0xFF at all times.
- R2: Offsets 0x51/0x52 hold the source high/low byte; source bits 3..0 are forced to zero, so the first read of a transfer is at {hi, lo & 0xF0}.
- R3: Offsets 0x53/0x54 hold the destination high/low byte; only destination bits 12..4 are kept and every write goes to 0x8000 | (dest & 0x1FF0) + offset, so a high byte of 0x96 and one of 0x16 give the same address, and the window wraps from 0x9FF0 to 0x8000.
- R4: Byte i of a block is read at source+i in one cycle and written, with the value read, at destination+i in the following cycle; no two consecutive cycles both write.
- R5: Writing offset 0x55 with bit 7 = 0 while no H-blank transfer is armed starts a general transfer of (N+1)×16 bytes, where N is bits 6..0. The stall output rises the cycle after the write and stays high for exactly 32×(N+1) cycles.
- R6: Writing offset 0x55 with bit 7 = 1 arms an H-blank transfer of N+1 blocks. Each H-blank pulse seen while armed and idle copies one block, with the stall output high for 32 cycles. Pulses that arrive during a block are ignored.
- R7: While a transfer is armed, offset 0x55 reads bit 7 = 0 and, in bits 6..0, the number of blocks still to copy minus one.
- R8: When the last block completes, offset 0x55 reads 0xFF.
- R9: After each block the internal source and destination both advance by 16, so a new start without reloading them continues at the next block.
- R10: Writing offset 0x55 with bit 7 = 0 while an H-blank transfer is armed and idle stops it. The register then reads bit 7 = 1 with the remaining count kept, and later H-blank pulses copy nothing.
- R11: Register writes are ignored while the stall output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 8 | Register offset |
| reg_wdata_i | input | 8 | Register write data |
| reg_we_i | input | 1 | Register write strobe |
| reg_rdata_o | output | 8 | Register read data, combinational from reg_addr_i |
| hblank_i | input | 1 | H-blank pulse |
| cpu_stall_o | output | 1 | High while a block is being copied |
| mem_addr_o | output | 16 | Memory master address |
| mem_rdata_i | input | 8 | Memory read data, valid in the same cycle |
| mem_wdata_o | output | 8 | Memory write data |
| mem_we_o | output | 1 | Memory write strobe |

## Verification
A control write or an H-blank pulse takes effect at the clock edge that samples it, so the stall output and the first source read appear one cycle later. The first destination write follows one cycle after that. The last write of an N-block general transfer lands 32×(N+1) cycles after the start, and the stall drops on the next cycle. Readback is combinational on the current state. The bench drives its inputs on falling edges and keeps a behavioural model of these latencies. It compares the model with the outputs a short delay after every falling edge, when registered and combinational values have settled. Directed checks count cycles from the start write to test the first read address, the first write address and a window wrap.

// File: rtl/vdma_pkg.sv
package vdma_pkg;
  localparam logic [7:0] OFS_SRC_HI = 8'h51;
  localparam logic [7:0] OFS_SRC_LO = 8'h52;
  localparam logic [7:0] OFS_DST_HI = 8'h53;
  localparam logic [7:0] OFS_DST_LO = 8'h54;
  localparam logic [7:0] OFS_CTRL   = 8'h55;
  localparam logic [7:0] RD_IDLE    = 8'hFF;

  typedef struct packed {
    logic src_hi;
    logic src_lo;
    logic dst_hi;
    logic dst_lo;
    logic ctrl;
  } reg_wr_t;
endpackage

// File: rtl/vdma_addr_regs.sv
module vdma_addr_regs #(
  parameter int ADDR_W  = 16,
  parameter int BLK_LG2 = 4,
  parameter int WIN_LG2 = 13,
  localparam int SRC_W  = ADDR_W - BLK_LG2,
  localparam int DST_W  = WIN_LG2 - BLK_LG2,
  localparam int LO_W   = 8 - BLK_LG2,
  localparam int DHI_W  = WIN_LG2 - 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  vdma_pkg::reg_wr_t wr_i,
  input  logic [7:0]       wdata_i,
  input  logic             adv_i,
  output logic [SRC_W-1:0] src_blk_o,
  output logic [DST_W-1:0] dst_blk_o
);
  logic [SRC_W-1:0] src_q;
  logic [DST_W-1:0] dst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q <= '0;
      dst_q <= '0;
    end else if (adv_i) begin
      src_q <= src_q + 1'b1;
      dst_q <= dst_q + 1'b1;
    end else begin
      if (wr_i.src_hi) src_q[SRC_W-1 -: 8]  <= wdata_i;
      if (wr_i.src_lo) src_q[LO_W-1:0]      <= wdata_i[7:BLK_LG2];
      // top bits of the destination high byte are dropped
      if (wr_i.dst_hi) dst_q[DST_W-1 -: DHI_W] <= wdata_i[DHI_W-1:0];
      if (wr_i.dst_lo) dst_q[LO_W-1:0]      <= wdata_i[7:BLK_LG2];
    end
  end

  assign src_blk_o = src_q;
  assign dst_blk_o = dst_q;
endmodule

// File: rtl/vdma_seq.sv
module vdma_seq #(
  parameter int BLK_LG2 = 4,
  parameter int LEN_W   = 7,
  localparam int CNT_W  = BLK_LG2 + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_we_i,
  input  logic [7:0]       wdata_i,
  input  logic             hblank_i,
  output logic             busy_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             adv_o,
  output logic [LEN_W:0]   ctrl_rd_o
);
  logic             active_q, hbl_q, busy_q;
  logic [LEN_W-1:0] len_q;
  logic [CNT_W-1:0] cnt_q;
  logic             blk_done;

  assign blk_done = busy_q && (cnt_q == '1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      hbl_q    <= 1'b0;
      busy_q   <= 1'b0;
      len_q    <= '1;
      cnt_q    <= '0;
    end else if (busy_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (blk_done) begin
        len_q <= len_q - 1'b1;  // wraps to all ones on the last block
        if (len_q == '0) begin
          active_q <= 1'b0;
          busy_q   <= 1'b0;
        end else if (hbl_q) begin
          busy_q <= 1'b0;
        end
      end
    end else if (ctrl_we_i) begin
      if (active_q && hbl_q && !wdata_i[7]) begin
        active_q <= 1'b0;
      end else begin
        active_q <= 1'b1;
        hbl_q    <= wdata_i[7];
        len_q    <= wdata_i[LEN_W-1:0];
        busy_q   <= !wdata_i[7];
        cnt_q    <= '0;
      end
    end else if (active_q && hbl_q && hblank_i) begin
      busy_q <= 1'b1;
    end
  end

  assign busy_o    = busy_q;
  assign cnt_o     = cnt_q;
  assign adv_o     = blk_done;
  assign ctrl_rd_o = {~active_q, len_q};
endmodule

// File: rtl/vdma_mover.sv
module vdma_mover #(
  parameter int          ADDR_W   = 16,
  parameter int          BLK_LG2  = 4,
  parameter int          WIN_LG2  = 13,
  parameter logic [15:0] WIN_ADDR = 16'h8000,
  localparam int SRC_W = ADDR_W - BLK_LG2,
  localparam int DST_W = WIN_LG2 - BLK_LG2,
  localparam int CNT_W = BLK_LG2 + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [SRC_W-1:0]  src_blk_i,
  input  logic [DST_W-1:0]  dst_blk_i,
  input  logic [7:0]        mem_rdata_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  output logic              mem_we_o
);
  logic               wr_phase;
  logic [BLK_LG2-1:0] off;
  logic [7:0]         buf_q;

  assign wr_phase = cnt_i[0];
  assign off      = cnt_i[CNT_W-1:1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                buf_q <= '0;
    else if (busy_i && !wr_phase) buf_q <= mem_rdata_i;
  end

  always_comb begin
    if (wr_phase) mem_addr_o = {WIN_ADDR[ADDR_W-1:WIN_LG2], dst_blk_i, off};
    else          mem_addr_o = {src_blk_i, off};
  end

  assign mem_wdata_o = buf_q;
  assign mem_we_o    = busy_i && wr_phase;
endmodule

// File: rtl/vdma_ctrl.sv
module vdma_ctrl #(
  parameter int          ADDR_W   = 16,
  parameter int          BLK_LG2  = 4,
  parameter int          WIN_LG2  = 13,
  parameter logic [15:0] WIN_ADDR = 16'h8000,
  localparam int LEN_W = 7,
  localparam int SRC_W = ADDR_W - BLK_LG2,
  localparam int DST_W = WIN_LG2 - BLK_LG2,
  localparam int CNT_W = BLK_LG2 + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  input  logic              reg_we_i,
  output logic [7:0]        reg_rdata_o,
  input  logic              hblank_i,
  output logic              cpu_stall_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [7:0]        mem_rdata_i,
  output logic [7:0]        mem_wdata_o,
  output logic              mem_we_o
);
  import vdma_pkg::*;

  reg_wr_t          wr;
  logic             wr_en, busy, adv;
  logic [CNT_W-1:0] cnt;
  logic [SRC_W-1:0] src_blk;
  logic [DST_W-1:0] dst_blk;
  logic [LEN_W:0]   ctrl_rd;

  assign wr_en     = reg_we_i && !busy;
  assign wr.src_hi = wr_en && (reg_addr_i == OFS_SRC_HI);
  assign wr.src_lo = wr_en && (reg_addr_i == OFS_SRC_LO);
  assign wr.dst_hi = wr_en && (reg_addr_i == OFS_DST_HI);
  assign wr.dst_lo = wr_en && (reg_addr_i == OFS_DST_LO);
  assign wr.ctrl   = wr_en && (reg_addr_i == OFS_CTRL);

  vdma_addr_regs #(.ADDR_W(ADDR_W), .BLK_LG2(BLK_LG2), .WIN_LG2(WIN_LG2)) u_addr (
    .clk_i, .rst_ni, .wr_i(wr), .wdata_i(reg_wdata_i), .adv_i(adv),
    .src_blk_o(src_blk), .dst_blk_o(dst_blk)
  );

  vdma_seq #(.BLK_LG2(BLK_LG2), .LEN_W(LEN_W)) u_seq (
    .clk_i, .rst_ni, .ctrl_we_i(wr.ctrl), .wdata_i(reg_wdata_i), .hblank_i,
    .busy_o(busy), .cnt_o(cnt), .adv_o(adv), .ctrl_rd_o(ctrl_rd)
  );

  vdma_mover #(.ADDR_W(ADDR_W), .BLK_LG2(BLK_LG2), .WIN_LG2(WIN_LG2),
               .WIN_ADDR(WIN_ADDR)) u_mover (
    .clk_i, .rst_ni, .busy_i(busy), .cnt_i(cnt), .src_blk_i(src_blk),
    .dst_blk_i(dst_blk), .mem_rdata_i, .mem_addr_o, .mem_wdata_o, .mem_we_o
  );

  assign reg_rdata_o = (reg_addr_i == OFS_CTRL) ? ctrl_rd : RD_IDLE;
  assign cpu_stall_o = busy;
endmodule

// File: rtl/vdma_ctrl_chk.sv
module vdma_ctrl_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cpu_stall_o,
  input logic [15:0] mem_addr_o,
  input logic [7:0]  mem_rdata_i,
  input logic [7:0]  mem_wdata_o,
  input logic        mem_we_o,
  input logic [7:0]  reg_addr_i,
  input logic [7:0]  reg_rdata_o
);
  AST_WR_IN_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_addr_o[15:13] == 3'b100); // R3
  AST_WR_AFTER_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> $past(cpu_stall_o) && !$past(mem_we_o)
                 && mem_addr_o[3:0] == $past(mem_addr_o[3:0])); // R4
  AST_WDATA_FROM_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_wdata_o == $past(mem_rdata_i)); // R4
  AST_NO_BACK2BACK_WE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !mem_we_o); // R4
  AST_FIRST_RD_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cpu_stall_o) |-> mem_addr_o[3:0] == 4'h0 && !mem_we_o); // R2
  AST_WE_NEEDS_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> cpu_stall_o); // R5
  AST_STALL_ENDS_ON_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cpu_stall_o) |-> $past(mem_we_o) && $past(mem_addr_o[3:0]) == 4'hF); // R6
  AST_OTHER_OFS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_addr_i != 8'h55 |-> reg_rdata_o == 8'hFF); // R1
endmodule

bind vdma_ctrl vdma_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cpu_stall_o(cpu_stall_o),
  .mem_addr_o(mem_addr_o), .mem_rdata_i(mem_rdata_i), .mem_wdata_o(mem_wdata_o),
  .mem_we_o(mem_we_o), .reg_addr_i(reg_addr_i), .reg_rdata_o(reg_rdata_o)
);

// File: tb/vdma_ctrl_tb.sv
`timescale 1ns/1ps
module vdma_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = 8'h55;
  logic [7:0]  reg_wdata = 8'h00;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_rdata;
  logic        hblank = 1'b0;
  logic        stall;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata;
  logic [7:0]  mem_wdata;
  logic        mem_we;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  function automatic logic [7:0] mem_fn(input int a);
    return 8'(a) ^ 8'(a >> 8) ^ 8'h5A;
  endfunction
  assign mem_rdata = mem_fn(int'(mem_addr));

  vdma_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_we_i(reg_we), .reg_rdata_o(reg_rdata), .hblank_i(hblank),
    .cpu_stall_o(stall), .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata),
    .mem_wdata_o(mem_wdata), .mem_we_o(mem_we)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // behavioural reference model
  int m_src, m_dst, m_rem, m_byte;
  bit m_act, m_hb, m_busy;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_src = 0; m_dst = 0; m_rem = 127; m_byte = 0;
      m_act = 0; m_hb = 0; m_busy = 0;
    end else if (m_busy) begin
      if (m_byte == 31) begin
        m_byte = 0;
        m_src = (m_src + 16) & 16'hFFFF;
        m_dst = (m_dst + 16) & 16'h1FF0;
        if (m_rem == 0) begin m_act = 0; m_busy = 0; m_rem = 127; end
        else begin m_rem = m_rem - 1; if (m_hb) m_busy = 0; end
      end else m_byte = m_byte + 1;
    end else if (reg_we) begin
      case (reg_addr)
        8'h51: m_src = (m_src & 16'h00F0) | (int'(reg_wdata) << 8);
        8'h52: m_src = (m_src & 16'hFF00) | (int'(reg_wdata) & 16'hF0);
        8'h53: m_dst = (m_dst & 16'h00F0) | ((int'(reg_wdata) & 16'h1F) << 8);
        8'h54: m_dst = (m_dst & 16'h1F00) | (int'(reg_wdata) & 16'hF0);
        8'h55: begin
          if (m_act && m_hb && !reg_wdata[7]) m_act = 0;
          else begin
            m_act = 1; m_hb = reg_wdata[7]; m_rem = int'(reg_wdata[6:0]);
            m_busy = !reg_wdata[7]; m_byte = 0;
          end
        end
        default: ;
      endcase
    end else if (m_act && m_hb && hblank) m_busy = 1;
  end

  // per-cycle comparison, away from the edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n && !finished) begin
      #2;
      check("R5 R6 stall", int'(stall), int'(m_busy));
      check("R4 we", int'(mem_we), int'(m_busy && (m_byte % 2 == 1)));
      if (m_busy) begin
        if (m_byte % 2 == 0) check("R2 R9 read addr", int'(mem_addr), (m_src + m_byte / 2) & 16'hFFFF);
        else begin
          check("R3 R9 write addr", int'(mem_addr), 16'h8000 | (m_dst + m_byte / 2));
          check("R4 wdata", int'(mem_wdata), int'(mem_fn(m_src + m_byte / 2)));
        end
      end
      if (reg_addr == 8'h55)
        check("R7 R8 R10 ctrl read", int'(reg_rdata), m_act ? m_rem : (128 | m_rem));
      else check("R1 other read", int'(reg_rdata), 8'hFF);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0; reg_addr = 8'h55;
  endtask

  task automatic pulse();
    @(negedge clk); hblank = 1'b1;
    @(negedge clk); hblank = 1'b0;
  endtask

  task automatic wait_idle();
    while (stall) @(negedge clk);
  endtask

  task automatic skip(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) if (cyc > 20000) begin
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    skip(3);
    #1 check("R1 reset ctrl", int'(reg_rdata), 8'hFF);
    check("R1 reset stall", int'(stall), 0);
    check("R1 reset we", int'(mem_we), 0);
    rst_n = 1'b1;
    skip(2);

    // general transfer, masked source and destination
    wr(8'h51, 8'h12); wr(8'h52, 8'h5F); wr(8'h53, 8'h96); wr(8'h54, 8'h23);
    wr(8'h55, 8'h01);
    #1 check("R2 first read", int'(mem_addr), 16'h1250);
    check("R5 stall starts", int'(stall), 1);
    @(negedge clk); #1 check("R3 first write", int'(mem_addr), 16'h9620);
    skip(62); #1 check("R5 still stalled", int'(stall), 1);
    @(negedge clk); #1 check("R5 stall ends", int'(stall), 0);
    check("R8 done", int'(reg_rdata), 8'hFF);

    // continue without reloading
    wr(8'h55, 8'h00);
    #1 check("R9 next src", int'(mem_addr), 16'h1270);
    @(negedge clk); #1 check("R9 next dst", int'(mem_addr), 16'h9640);
    wait_idle();

    // high byte 0x16 gives same window address as 0x96
    wr(8'h53, 8'h16); wr(8'h54, 8'h20); wr(8'h55, 8'h00);
    @(negedge clk); #1 check("R3 alias write", int'(mem_addr), 16'h9620);
    wait_idle();

    // writes during stall ignored
    wr(8'h55, 8'h03);
    skip(3);
    @(negedge clk); reg_addr = 8'h51; reg_wdata = 8'hAA; reg_we = 1'b1;
    @(negedge clk); reg_addr = 8'h55; reg_wdata = 8'h80;
    @(negedge clk); reg_we = 1'b0;
    wait_idle();
    #1 check("R11 ctrl after ignored", int'(reg_rdata), 8'hFF);
    wr(8'h55, 8'h00);
    #1 check("R11 src kept", int'(mem_addr), 16'h12D0);
    wait_idle();

    // destination window wrap
    wr(8'h53, 8'h1F); wr(8'h54, 8'hF0); wr(8'h55, 8'h01);
    @(negedge clk); #1 check("R3 top of window", int'(mem_addr), 16'h9FF0);
    skip(32); #1 check("R3 wrap to base", int'(mem_addr), 16'h8000);
    wait_idle();

    // H-blank paced transfer
    wr(8'h55, 8'h82);
    #1 check("R7 armed", int'(reg_rdata), 8'h02);
    check("R6 no stall before pulse", int'(stall), 0);
    skip(5);
    pulse();
    #1 check("R6 block starts", int'(stall), 1);
    skip(4); pulse();
    wait_idle();
    #1 check("R7 one block done", int'(reg_rdata), 8'h01);
    skip(3);
    check("R6 idle between pulses", int'(stall), 0);
    wr(8'h55, 8'h00);
    #1 check("R10 stopped", int'(reg_rdata), 8'h81);
    pulse();
    #1 check("R10 no copy after stop", int'(stall), 0);
    wr(8'h55, 8'h80);
    pulse(); wait_idle();
    #1 check("R8 hblank done", int'(reg_rdata), 8'hFF);
    pulse();
    #1 check("R8 no copy after done", int'(stall), 0);
    skip(3);
    finish_run();
  end
endmodule